// File: doc/BRIEF.md
# Video Interrupt Controller

This block gathers four interrupt causes from a video and audio subsystem and merges them into one interrupt request line to the CPU. The causes are the frame vertical sync, the current scanline reaching a programmed compare line, a sprite collision, and the audio sample buffer running low. Three of the causes are latched as sticky flags, and software clears each one by writing a 1 to its status bit. The audio cause is a level: it follows the buffer-low indication and only goes away when the buffer is refilled.

Software reaches the block through a small byte-wide register port with three addresses. The first address holds the enable mask. Its spare bits also carry the ninth bit of the compare line (write-only) and the ninth bit of the live scanline (read-only). The second address is the status register. It holds the four flags and the 4-bit collision data that was captured with the collision flag. The third address is shared: a write sets the low eight bits of the compare line, and a read returns the low eight bits of the live scanline. The video timing and the collision detector are outside the block and drive its inputs.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After synchronous active-low reset, the enable mask, compare line, all status flags and the collision data are zero, and `irq` is low.
- R2: Enable register (address 0) layout. Write bits 3:0 set the enables in this order: bit 0 vsync, bit 1 raster line, bit 2 collision, bit 3 audio low. Write bit 7 sets compare-line bit 8. A read returns the enables in bits 3:0, scanline bit 8 in bit 6, and zero in bits 7, 5 and 4.
- R3: Address 2 is shared. A write sets compare-line bits 7:0. A read returns scanline bits 7:0.
- R4: A one-cycle `vsync_pulse` sets status bit 0. The flag stays set until a write to address 1 with data bit 0 high. A write with that bit low leaves it set.
- R5: Status bit 1 sets on the first clock on which the 9-bit scanline equals the 9-bit compare line. If the flag is cleared while the scanline is still equal, it does not set again until equality is lost and then regained. A match on the low eight bits alone does not count. Equality that already holds when reset is released is not a new match.
- R6: A `coll_pulse` sets status bit 2 and captures `coll_data` into status bits 7:4. Further pulses while the flag is set do not change the captured data. Clearing the flag through status write bit 2 also zeroes the data.
- R7: Status bit 3 shows `audio_low` as registered one clock earlier. A write of 1 to status bit 3 has no effect.
- R8: `irq` is high exactly when some status bit 3:0 is set and its enable bit is set. Status bits of disabled sources still latch.
- R9: When a source's set condition and its write-1 clear occur in the same clock, the set wins.
- R10: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| scanline | input | 9 | Current scanline number |
| vsync_pulse | input | 1 | One-cycle vertical sync event |
| coll_pulse | input | 1 | One-cycle sprite collision event |
| coll_data | input | 4 | Collision data that accompanies `coll_pulse` |
| audio_low | input | 1 | Audio buffer below one quarter full |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every event and every register write takes effect at the clock edge where it is sampled. Its result can be read at the port during the next cycle, because `reg_rdata` and `irq` decode registered state directly. The audio flag also has one register of delay, so it follows `audio_low` one edge later. The bench changes inputs on the falling edge and checks results on the following falling edge, after the single rising edge that applies them. A sweep over every enable mask and every combination of active sources compares status and `irq` against values built from the mask in the bench.

// File: rtl/vid_irq_pkg.sv
// Package: shared constants for the video interrupt controller.
// Assumes a byte-wide register port with a two-bit address.
package vid_irq_pkg;
    localparam int REG_AW  = 2;
    localparam int REG_DW  = 8;
    localparam int LINE_W  = 9;
    localparam int NSRC    = 4;
    localparam int CDATA_W = 4;
    localparam int NLATCH  = 3;

    localparam logic [REG_AW-1:0] A_ENABLE = 2'd0;
    localparam logic [REG_AW-1:0] A_STATUS = 2'd1;
    localparam logic [REG_AW-1:0] A_LINE   = 2'd2;

    typedef enum int {
        SRC_VSYNC = 0,
        SRC_LINE  = 1,
        SRC_COLL  = 2,
        SRC_AUDIO = 3
    } src_e;

    localparam int EN_LINE_HI_BIT   = 7;
    localparam int EN_SCAN_HI_BIT   = 6;
endpackage

// File: rtl/vid_irq_linecmp.sv
// Module: raster line compare edge detector.
// Asserts hit for one clock on the first cycle the scanline equals the
// compare line. Assumes both inputs are stable between clock edges.
module vid_irq_linecmp #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] scanline,
    input  logic [LINE_W-1:0] cmp_line,
    output logic              hit
);
    logic match_now;
    logic match_q;

    // Combinational equality of live scanline and programmed line.
    always_comb match_now = (scanline == cmp_line);

    // Remember last cycle's equality; reset as matched so no hit at release.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match_now;
    end

    // Rising edge of equality.
    always_comb hit = match_now && !match_q;

    p_hit_only_on_new_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (scanline == cmp_line) && !$past(scanline == cmp_line));
endmodule

// File: rtl/vid_irq_status.sv
// Module: status flags and collision data capture.
// Latched sources set on their event and clear on a write-1 mask; set wins.
// The audio flag is a registered copy of the buffer-low level.
module vid_irq_status #(
    parameter int NSRC    = 4,
    parameter int CDATA_W = 4,
    parameter int NLATCH  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLATCH-1:0]  set_ev,
    input  logic [NLATCH-1:0]  clr_mask,
    input  logic [CDATA_W-1:0] coll_data,
    input  logic               audio_low,
    output logic [NSRC-1:0]    flags,
    output logic [CDATA_W-1:0] cdata
);
    import vid_irq_pkg::*;

    logic [NLATCH-1:0]  sticky_q;
    logic               aud_q;
    logic [CDATA_W-1:0] cdata_q;
    logic               coll_take;

    // One sticky flag per latched source.
    for (genvar g = 0; g < NLATCH; g++) begin : g_sticky
        // Set has priority over the software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            sticky_q[g] <= 1'b0;
            else if (set_ev[g])    sticky_q[g] <= 1'b1;
            else if (clr_mask[g])  sticky_q[g] <= 1'b0;
        end
    end

    // Registered copy of the audio buffer-low level.
    always_ff @(posedge clk) begin
        if (!rst_n) aud_q <= 1'b0;
        else        aud_q <= audio_low;
    end

    // Capture collision data only when the flag is free or being cleared.
    always_comb coll_take = set_ev[SRC_COLL] && (!sticky_q[SRC_COLL] || clr_mask[SRC_COLL]);

    // Collision data register: load on take, zero on clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cdata_q <= '0;
        else if (coll_take)          cdata_q <= coll_data;
        else if (set_ev[SRC_COLL])   cdata_q <= cdata_q;
        else if (clr_mask[SRC_COLL]) cdata_q <= '0;
    end

    // Assemble outputs.
    always_comb begin
        flags = '0;
        flags[NLATCH-1:0] = sticky_q;
        flags[SRC_AUDIO]  = aud_q;
        cdata = cdata_q;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[SRC_VSYNC] |=> flags[SRC_VSYNC]);
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags[SRC_VSYNC] && !clr_mask[SRC_VSYNC] |=> flags[SRC_VSYNC]);
    p_line_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[SRC_LINE] |=> flags[SRC_LINE]);
    p_cdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[SRC_COLL] && !clr_mask[SRC_COLL] |=> $stable(cdata));
    p_audio_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> flags[SRC_AUDIO] == $past(audio_low));
endmodule

// File: rtl/vid_irq_regs.sv
// Module: register file and read decode.
// Holds the enable mask and the 9-bit compare line, produces the write-1
// clear mask for status, and multiplexes read data. Reads have no side effect.
module vid_irq_regs #(
    parameter int REG_AW  = 2,
    parameter int REG_DW  = 8,
    parameter int LINE_W  = 9,
    parameter int NSRC    = 4,
    parameter int CDATA_W = 4,
    parameter int NLATCH  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    input  logic [LINE_W-1:0]  scanline,
    input  logic [NSRC-1:0]    flags,
    input  logic [CDATA_W-1:0] cdata,
    output logic [NSRC-1:0]    enables,
    output logic [LINE_W-1:0]  cmp_line,
    output logic [NLATCH-1:0]  clr_mask
);
    import vid_irq_pkg::*;

    localparam int LOW_W = LINE_W - 1;

    logic [NSRC-1:0]   en_q;
    logic [LINE_W-1:0] cmp_q;
    logic              wr_en_reg;
    logic              wr_line_reg;
    logic              wr_status;

    // Decode write strobes per address.
    always_comb begin
        wr_en_reg   = reg_we && (reg_addr == A_ENABLE);
        wr_status   = reg_we && (reg_addr == A_STATUS);
        wr_line_reg = reg_we && (reg_addr == A_LINE);
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_en_reg) en_q <= reg_wdata[NSRC-1:0];
    end

    // Compare line: top bit from enable address, low bits from line address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            if (wr_en_reg)   cmp_q[LINE_W-1]  <= reg_wdata[EN_LINE_HI_BIT];
            if (wr_line_reg) cmp_q[LOW_W-1:0] <= reg_wdata[LOW_W-1:0];
        end
    end

    // Write-1 clear mask for the latched sources.
    always_comb clr_mask = wr_status ? reg_wdata[NLATCH-1:0] : '0;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE: begin
                reg_rdata[NSRC-1:0]      = en_q;
                reg_rdata[EN_SCAN_HI_BIT] = scanline[LINE_W-1];
            end
            A_STATUS: reg_rdata = {cdata, flags};
            A_LINE:   reg_rdata = scanline[LOW_W-1:0];
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        enables  = en_q;
        cmp_line = cmp_q;
    end

    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_reg |=> enables == $past(reg_wdata[NSRC-1:0]));
    p_line_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_line_reg |=> cmp_line[LOW_W-1:0] == $past(reg_wdata[LOW_W-1:0]));
    p_status_write_keeps_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> $stable(enables) && $stable(cmp_line));
endmodule

// File: rtl/vid_irq_ctrl.sv
// Module: top of the four-source video interrupt controller.
// Connects the line comparator, the status flags and the register file and
// drives one active-high interrupt request. Assumes event pulses are one
// clock wide and all inputs are synchronous to clk.
module vid_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [8:0] scanline,
    input  logic       vsync_pulse,
    input  logic       coll_pulse,
    input  logic [3:0] coll_data,
    input  logic       audio_low,
    output logic       irq
);
    import vid_irq_pkg::*;

    logic [NSRC-1:0]    flags;
    logic [CDATA_W-1:0] cdata;
    logic [NSRC-1:0]    enables;
    logic [LINE_W-1:0]  cmp_line;
    logic [NLATCH-1:0]  clr_mask;
    logic [NLATCH-1:0]  set_ev;
    logic               line_hit;

    vid_irq_linecmp #(.LINE_W(LINE_W)) u_linecmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scanline (scanline),
        .cmp_line (cmp_line),
        .hit      (line_hit)
    );

    // Gather the set events of the latched sources in status bit order.
    always_comb begin
        set_ev            = '0;
        set_ev[SRC_VSYNC] = vsync_pulse;
        set_ev[SRC_LINE]  = line_hit;
        set_ev[SRC_COLL]  = coll_pulse;
    end

    vid_irq_status #(
        .NSRC    (NSRC),
        .CDATA_W (CDATA_W),
        .NLATCH  (NLATCH)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (set_ev),
        .clr_mask  (clr_mask),
        .coll_data (coll_data),
        .audio_low (audio_low),
        .flags     (flags),
        .cdata     (cdata)
    );

    vid_irq_regs #(
        .REG_AW  (REG_AW),
        .REG_DW  (REG_DW),
        .LINE_W  (LINE_W),
        .NSRC    (NSRC),
        .CDATA_W (CDATA_W),
        .NLATCH  (NLATCH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scanline  (scanline),
        .flags     (flags),
        .cdata     (cdata),
        .enables   (enables),
        .cmp_line  (cmp_line),
        .clr_mask  (clr_mask)
    );

    // Request is any enabled, set status flag.
    always_comb irq = |(flags & enables);

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enables != '0) && (flags != '0));
    p_vsync_latches_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> reg_addr != A_STATUS || reg_rdata[SRC_VSYNC]);
endmodule

// File: tb/vid_irq_ctrl_tb.sv
module vid_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [8:0] scanline = 9'd0;
    logic       vsync_pulse = 1'b0;
    logic       coll_pulse = 1'b0;
    logic [3:0] coll_data = 4'd0;
    logic       audio_low = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [8:0] CMPV = 9'h1A0;

    always #10 clk = ~clk;

    vid_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scanline(scanline),
        .vsync_pulse(vsync_pulse), .coll_pulse(coll_pulse), .coll_data(coll_data),
        .audio_low(audio_low), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One clock: inputs set before this call, results valid on return.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(2'd0, v); chk("R1 enable", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 enable layout and scanline bit 8
        scanline = 9'h1C3;
        wr(2'd0, 8'h8F);
        rd(2'd0, v); chk("R2 enable read", v, 8'h4F);
        // R3 shared line address
        rd(2'd2, v); chk("R3 scanline low", v, 8'hC3);
        // R10 unused address
        rd(2'd3, v); chk("R10 addr3", v, 8'h00);
        scanline = 9'd0; tick();

        // R5 compare: program 0x1A0, low-only match must not set
        wr(2'd0, 8'h80); wr(2'd2, 8'hA0);
        scanline = 9'h0A0; tick();
        rd(2'd1, v); chk("R5 low-only match", v, 8'h00);
        scanline = CMPV; tick();
        rd(2'd1, v); chk("R5 match sets", v, 8'h02);
        wr(2'd1, 8'h02); tick();
        rd(2'd1, v); chk("R5 no re-set while equal", v, 8'h00);
        scanline = 9'd0; tick(); scanline = CMPV; tick();
        rd(2'd1, v); chk("R5 re-set after regain", v, 8'h02);
        scanline = 9'd0; wr(2'd1, 8'h02);

        // R4 write 0 leaves, write 1 clears
        vsync_pulse = 1'b1; tick(); vsync_pulse = 1'b0;
        wr(2'd1, 8'hFE);
        rd(2'd1, v); chk("R4 write0 keeps", v, 8'h01);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R4 write1 clears", v, 8'h00);

        // R9 set wins
        vsync_pulse = 1'b1; wr(2'd1, 8'h01); vsync_pulse = 1'b0;
        rd(2'd1, v); chk("R9 set wins", v, 8'h01);
        wr(2'd1, 8'h01);

        // R6 collision data capture and hold
        coll_pulse = 1'b1; coll_data = 4'h5; tick();
        coll_data = 4'hC; tick(); coll_pulse = 1'b0;
        rd(2'd1, v); chk("R6 data held", v, 8'h54);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R6 clear zeroes data", v, 8'h00);

        // R7 audio level, write cannot clear
        audio_low = 1'b1; tick();
        wr(2'd1, 8'h08);
        rd(2'd1, v); chk("R7 write ignored", v, 8'h08);
        audio_low = 1'b0; tick();
        rd(2'd1, v); chk("R7 follows refill", v, 8'h00);

        // R8 sweep: every enable mask against every source combination
        for (int en = 0; en < 16; en++) begin
            wr(2'd0, {1'b1, 3'b000, en[3:0]});
            for (int p = 0; p < 16; p++) begin
                vsync_pulse = p[0]; coll_pulse = p[2]; coll_data = 4'hA;
                scanline = p[1] ? CMPV : 9'd0; audio_low = p[3];
                tick();
                vsync_pulse = 1'b0; coll_pulse = 1'b0; scanline = 9'd0;
                tick();
                rd(2'd1, v);
                chk("R8 status latch", v, {(p[2] ? 4'hA : 4'h0), p[3:0]});
                chk("R8 irq", {7'd0, irq}, {7'd0, |(p[3:0] & en[3:0])});
                audio_low = 1'b0;
                wr(2'd1, 8'h07);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule